// File: doc/BRIEF.md
# Transmit Loopback Checker with Overrun Watchdog

This block guards the transmit side of a serial bus controller. Each word the controller puts on the bus is announced with a strobe. The block keeps a copy of that word, its sync type and an implied good parity. The receiver decodes the echoed copy of the transmission and presents it back to the block. The block compares the echo with the held copy. It flags a one-cycle loopback failure when the two differ. It also flags a failure when the echo never arrives, or when a new word starts before the previous echo was seen. That last case is what happens when a late terminal response collides with the next command, and the controller uses the pulse to retry the message.

A second function watches the transmitter-active signal. A prescaler turns clock cycles into microsecond ticks, and a counter accumulates ticks for as long as transmission continues. The counter restarts whenever the transmitter goes idle. When continuous transmission exceeds the configured limit, the watchdog trips once for that burst.

Both fault sources set a sticky shutdown status bit. The bit raises a one-cycle interrupt when it is first set, and it holds the transmit-disable output asserted. Software clears the bit with a clear strobe.

Top module: `lbk_guard`

## Requirements
- R1: A word strobed on `tx_stb` is held, and its echo (`rx_stb`) is compared in 16 data bits, sync type (`1` = command/status sync, `0` = data sync) and parity-valid (`1` = good). An exact match with good parity gives no failure.
- R2: A difference in any of the 16 data bits makes `lb_fail` high for exactly one cycle, namely the cycle after the clock edge that samples the echo strobe.
- R3: A sync-type difference, or an echo with `rx_par_ok` = 0, is also a failure with the same timing as R2.
- R4: An echo is accepted at any of the ECHO_WAIT edges that follow the edge sampling `tx_stb`. If none arrives, `lb_fail` pulses after the last of those edges.
- R5: A new `tx_stb` while an echo is still awaited is a failure for the old word. The new word becomes the held copy, and its own echo is compared normally.
- R6: An echo strobe while no echo is awaited is ignored and causes no failure.
- R7: With `tx_active` high for (LIMIT_US+1)*CLKS_PER_US consecutive sampled edges, the watchdog trips on the last of them. It trips only once per continuous burst.
- R8: Any sampled edge with `tx_active` low restarts the watchdog count from zero.
- R9: `sd_status` is set on the edge after a loopback failure or a watchdog trip. It stays set until an edge that samples `sd_clr` high without a new fault; a fault wins over a simultaneous clear.
- R10: `tx_disable` is high exactly when `sd_status` is high.
- R11: `sd_irq` pulses for one cycle, together with the 0-to-1 change of `sd_status`, and never while the status was already set.
- R12: After reset, `lb_fail`, `sd_status`, `sd_irq` and `tx_disable` are all low and no echo is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_stb | input | 1 | A word is being transmitted |
| tx_word | input | 16 | Transmitted data bits |
| tx_sync_cmd | input | 1 | Transmitted sync type, 1 = command/status |
| rx_stb | input | 1 | Receiver decoded a word |
| rx_word | input | 16 | Decoded data bits |
| rx_sync_cmd | input | 1 | Decoded sync type, 1 = command/status |
| rx_par_ok | input | 1 | Decoded parity was valid |
| tx_active | input | 1 | Transmitter is driving the bus |
| sd_clr | input | 1 | Software clear of the shutdown status |
| lb_fail | output | 1 | One-cycle loopback failure pulse |
| sd_status | output | 1 | Sticky transmitter-shutdown status |
| sd_irq | output | 1 | One-cycle shutdown interrupt |
| tx_disable | output | 1 | Forced transmitter disable |

## Verification
The compare is driven with random words and random echo delays across the whole acceptance window. Each word either comes back exactly or is damaged in one of three ways: a single flipped data bit, a flipped sync type, or bad parity. This separates the data, sync and parity paths from each other.

Directed sequences cover the remaining cases:
- a missing echo, checked on both sides of the window end;
- back-to-back words, which show whether the held copy is replaced;
- a stray echo with nothing outstanding.

The watchdog is held active one edge short of its limit and then to the limit, and it is also run with a single idle gap, to tell an off-by-one from a missing restart. A fault timed to coincide with a software clear shows that setting wins over clearing, and the interrupt is seen to pulse only on the first rise of the status.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              sync_cmd;
    logic              par_ok;
  } lbk_word_t;
endpackage

// File: rtl/lbk_echo_cmp.sv
module lbk_echo_cmp
  import lbk_pkg::*;
#(
  parameter int ECHO_WAIT = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_stb,
  input  lbk_word_t tx_w,
  input  logic      rx_stb,
  input  lbk_word_t rx_w,
  output logic      fail
);
  localparam int CW = (ECHO_WAIT > 1) ? $clog2(ECHO_WAIT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ECHO_WAIT - 1);

  lbk_word_t       hold_q, hold_n;
  logic            pend_q, pend_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            fail_q, fail_n;
  logic            hold_en;
  logic            mism;

  assign mism    = (rx_w.data != hold_q.data) || (rx_w.sync_cmd != hold_q.sync_cmd) || !rx_w.par_ok;
  assign hold_en = tx_stb;

  always_comb begin
    pend_n = pend_q;
    cnt_n  = cnt_q;
    fail_n = 1'b0;
    hold_n = hold_q;
    if (pend_q) begin
      if (rx_stb) begin
        fail_n = mism;
        pend_n = 1'b0;
      end else if (tx_stb) begin
        fail_n = 1'b1;
      end else if (cnt_q == CNT_LAST) begin
        fail_n = 1'b1;
        pend_n = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    if (tx_stb) begin
      hold_n        = tx_w;
      hold_n.par_ok = 1'b1;
      pend_n        = 1'b1;
      cnt_n         = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
      fail_q <= fail_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_n;
    end
  end

  assign fail = fail_q;

  // R1: a transmitted word is always awaited next cycle
  assert_pend_after_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> pend_q);
  // R2: failure only reported when an echo was outstanding
  assert_fail_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> $past(pend_q));
  // R4: expired window with no echo gives a failure
  assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rx_stb && !tx_stb && cnt_q == CNT_LAST) |=> (fail_q && !pend_q));
  // R6: no failure arises while nothing is awaited
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q) |=> !fail_q);
endmodule

// File: rtl/lbk_tx_watchdog.sv
module lbk_tx_watchdog #(
  parameter int CLKS_PER_US = 50,
  parameter int LIMIT_US    = 688
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  output logic trip
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int UW = $clog2(LIMIT_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);
  localparam logic [UW-1:0] US_LIM   = UW'(LIMIT_US);

  logic [PW-1:0] pre_q, pre_n;
  logic [UW-1:0] us_q, us_n;
  logic          done_q, done_n;
  logic          trip_q, trip_n;
  logic          tick;

  assign tick = tx_active && !done_q && (pre_q == PRE_LAST);

  always_comb begin
    pre_n  = pre_q;
    us_n   = us_q;
    done_n = done_q;
    trip_n = 1'b0;
    if (!tx_active) begin
      pre_n  = '0;
      us_n   = '0;
      done_n = 1'b0;
    end else if (!done_q) begin
      if (tick) begin
        pre_n = '0;
        if (us_q == US_LIM) begin
          trip_n = 1'b1;
          done_n = 1'b1;
        end else begin
          us_n = us_q + 1'b1;
        end
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      us_q   <= '0;
      done_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      pre_q  <= pre_n;
      us_q   <= us_n;
      done_q <= done_n;
      trip_q <= trip_n;
    end
  end

  assign trip = trip_q;

  // R7: microsecond count never passes the limit
  assert_us_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= US_LIM);
  // R7: single trip per burst
  assert_single_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> !trip_q);
  // R8: idle edge restarts the count
  assert_idle_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> (us_q == '0 && pre_q == '0 && !trip_q));
endmodule

// File: rtl/lbk_shut_stat.sv
module lbk_shut_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_fault,
  input  logic ovr_fault,
  input  logic sw_clr,
  output logic status,
  output logic irq
);
  logic sts_q, sts_n;
  logic irq_q, irq_n;
  logic fault;

  assign fault = lb_fault || ovr_fault;

  always_comb begin
    sts_n = sts_q;
    irq_n = 1'b0;
    if (fault) begin
      sts_n = 1'b1;
      irq_n = !sts_q;
    end else if (sw_clr) begin
      sts_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      irq_q <= irq_n;
    end
  end

  assign status = sts_q;
  assign irq    = irq_q;

  // R9: any fault sets the status on the next edge
  assert_fault_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> sts_q);
  // R9: status holds without a clear
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sw_clr) |=> sts_q);
  // R11: interrupt only on a fresh rise
  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (sts_q && !$past(sts_q)));
endmodule

// File: rtl/lbk_guard.sv
module lbk_guard
  import lbk_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int LIMIT_US    = 688,
  parameter int ECHO_WAIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_stb,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_sync_cmd,
  input  logic              rx_stb,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_sync_cmd,
  input  logic              rx_par_ok,
  input  logic              tx_active,
  input  logic              sd_clr,
  output logic              lb_fail,
  output logic              sd_status,
  output logic              sd_irq,
  output logic              tx_disable
);
  lbk_word_t tx_w, rx_w;
  logic      fail_w, trip_w, sts_w;

  assign tx_w = '{data: tx_word, sync_cmd: tx_sync_cmd, par_ok: 1'b1};
  assign rx_w = '{data: rx_word, sync_cmd: rx_sync_cmd, par_ok: rx_par_ok};

  lbk_echo_cmp #(.ECHO_WAIT(ECHO_WAIT)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tx_stb(tx_stb), .tx_w(tx_w),
    .rx_stb(rx_stb), .rx_w(rx_w), .fail(fail_w)
  );

  lbk_tx_watchdog #(.CLKS_PER_US(CLKS_PER_US), .LIMIT_US(LIMIT_US)) u_wdg (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .trip(trip_w)
  );

  lbk_shut_stat u_stat (
    .clk(clk), .rst_n(rst_n), .lb_fault(fail_w), .ovr_fault(trip_w),
    .sw_clr(sd_clr), .status(sts_w), .irq(sd_irq)
  );

  assign lb_fail    = fail_w;
  assign sd_status  = sts_w;
  assign tx_disable = sts_w;

  // R10: disable follows status at the ports
  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_status) |-> tx_disable);
endmodule

// File: tb/test_lbk_guard.sv
module test_lbk_guard;
  localparam int C = 4;
  localparam int L = 10;
  localparam int W = 6;
  localparam int TRIP_EDGES = (L + 1) * C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_stb, tx_sync_cmd, rx_stb, rx_sync_cmd, rx_par_ok, tx_active, sd_clr;
  logic [15:0] tx_word, rx_word;
  logic        lb_fail, sd_status, sd_irq, tx_disable;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  lbk_guard #(.CLKS_PER_US(C), .LIMIT_US(L), .ECHO_WAIT(W)) i_lbk_guard (
    .clk(clk), .rst_n(rst_n), .tx_stb(tx_stb), .tx_word(tx_word), .tx_sync_cmd(tx_sync_cmd),
    .rx_stb(rx_stb), .rx_word(rx_word), .rx_sync_cmd(rx_sync_cmd), .rx_par_ok(rx_par_ok),
    .tx_active(tx_active), .sd_clr(sd_clr), .lb_fail(lb_fail), .sd_status(sd_status),
    .sd_irq(sd_irq), .tx_disable(tx_disable)
  );

  function automatic logic exp_fail(logic [15:0] tw, logic tc, logic [15:0] rw, logic rc, logic rp);
    return (tw != rw) || (tc != rc) || !rp;
  endfunction

  task automatic chk(logic got, logic exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // transmit at one edge, echo d edges later; returns lb_fail after echo edge
  task automatic xfer(logic [15:0] tw, logic tc, logic [15:0] rw, logic rc, logic rp,
                      int d, output logic got);
    tx_stb = 1'b1; tx_word = tw; tx_sync_cmd = tc;
    tick();
    tx_stb = 1'b0;
    repeat (d - 1) tick();
    rx_stb = 1'b1; rx_word = rw; rx_sync_cmd = rc; rx_par_ok = rp;
    tick();
    rx_stb = 1'b0;
    got = lb_fail;
  endtask

  task automatic clear_status();
    sd_clr = 1'b1; tick(); sd_clr = 1'b0;
  endtask

  initial begin
    logic got;
    rst_n = 1'b0; tx_stb = 0; rx_stb = 0; tx_word = 0; rx_word = 0;
    tx_sync_cmd = 0; rx_sync_cmd = 0; rx_par_ok = 1; tx_active = 0; sd_clr = 0;
    void'($urandom(32'h5eed));
    repeat (3) tick();
    chk(lb_fail, 0, "R12 lb_fail"); chk(sd_status, 0, "R12 status");
    chk(sd_irq, 0, "R12 irq");      chk(tx_disable, 0, "R12 disable");
    rst_n = 1'b1;
    tick();

    // R1 exact echo, boundary delays
    xfer(16'hA5C3, 1, 16'hA5C3, 1, 1, 1, got); chk(got, 0, "R1 match d=1");
    xfer(16'h0F0F, 0, 16'h0F0F, 0, 1, W, got); chk(got, 0, "R1 match d=W");
    chk(sd_status, 0, "R1 no status");

    // R2 data bit flip
    xfer(16'h1234, 0, 16'h1235, 0, 1, 2, got); chk(got, 1, "R2 data bit");
    tick(); chk(lb_fail, 0, "R2 one cycle");
    chk(sd_status, 1, "R9 set by fail"); chk(tx_disable, 1, "R10 disable");
    clear_status(); chk(sd_status, 0, "R9 cleared"); chk(tx_disable, 0, "R10 released");

    // R3 sync and parity
    xfer(16'h8001, 1, 16'h8001, 0, 1, 3, got); chk(got, 1, "R3 sync type");
    tick();
    xfer(16'h8001, 1, 16'h8001, 1, 0, 3, got); chk(got, 1, "R3 parity");
    tick(); clear_status();

    // R4 missing echo
    tx_stb = 1'b1; tx_word = 16'h7777; tx_sync_cmd = 1'b0; tick(); tx_stb = 1'b0;
    repeat (W - 1) tick();
    chk(lb_fail, 0, "R4 before window end");
    tick();
    chk(lb_fail, 1, "R4 timeout");
    // set wins over clear: status sets on next edge while clear is driven
    chk(sd_status, 0, "R9 before set");
    sd_clr = 1'b1; tick(); sd_clr = 1'b0;
    chk(sd_status, 1, "R9 set wins over clear"); chk(sd_irq, 1, "R11 irq rise");
    tick(); chk(sd_irq, 0, "R11 irq one cycle");
    // further fault while set: no irq
    xfer(16'h0001, 0, 16'h0002, 0, 1, 1, got); chk(got, 1, "R2 second fault");
    tick(); chk(sd_irq, 0, "R11 no irq when already set");
    clear_status();

    // R5 back-to-back words
    tx_stb = 1'b1; tx_word = 16'hAAAA; tx_sync_cmd = 1'b1; tick();
    tx_word = 16'h5555; tx_sync_cmd = 1'b0; tick(); tx_stb = 1'b0;
    chk(lb_fail, 1, "R5 overwritten echo");
    rx_stb = 1'b1; rx_word = 16'h5555; rx_sync_cmd = 1'b0; rx_par_ok = 1'b1; tick(); rx_stb = 1'b0;
    chk(lb_fail, 0, "R5 new word held");
    tick(); clear_status();

    // R6 stray echo
    rx_stb = 1'b1; rx_word = 16'hDEAD; rx_sync_cmd = 1'b1; rx_par_ok = 1'b0; tick(); rx_stb = 1'b0;
    chk(lb_fail, 0, "R6 stray echo");
    tick(); chk(sd_status, 0, "R6 status untouched");

    // random compare
    for (int i = 0; i < 80; i++) begin
      logic [15:0] tw, rw; logic tc, rc, rp; int kind, d;
      tw = 16'($urandom); tc = 1'($urandom); rw = tw; rc = tc; rp = 1'b1;
      kind = int'($urandom_range(0, 3)); d = int'($urandom_range(1, W));
      if (kind == 1) rw[$urandom_range(0, 15)] ^= 1'b1;
      else if (kind == 2) rc = ~tc;
      else if (kind == 3) rp = 1'b0;
      xfer(tw, tc, rw, rc, rp, d, got);
      chk(got, exp_fail(tw, tc, rw, rc, rp), "R1 R2 R3 random compare");
    end
    tick(); clear_status();

    // R7 watchdog trip
    tx_active = 1'b1;
    repeat (TRIP_EDGES) tick();
    chk(sd_status, 0, "R7 not yet tripped");
    tick();
    chk(sd_status, 1, "R7 tripped"); chk(sd_irq, 1, "R11 irq on trip");
    clear_status();
    repeat (3 * TRIP_EDGES) tick();
    chk(sd_status, 0, "R7 single trip per burst");
    tx_active = 1'b0; tick();

    // R8 idle gap restarts count
    tx_active = 1'b1; repeat (TRIP_EDGES - 4) tick();
    tx_active = 1'b0; tick();
    tx_active = 1'b1; repeat (TRIP_EDGES - 4) tick();
    tick();
    chk(sd_status, 0, "R8 gap restarted count");
    repeat (4) tick();
    chk(sd_status, 1, "R8 trip after full burst");
    tx_active = 1'b0;
    clear_status();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule